// File: doc/BRIEF.md
# Light-Sensor Integration Timing Controller

This block sets the conversion periods of an integrating light-sensor front end. It counts the count-enable pulses from a charge-balancing modulator over one integration window. When the window closes it publishes the pulse count as the sensor result and the window length in oscillator cycles as the timer result. A one-cycle end-of-conversion strobe marks each new pair. The window is either a fixed power-of-two number of oscillator cycles that restarts by itself, or the span between two sync strobes from the bus interface.

A dual-speed oscillator model supplies a clock enable. The range code picks half speed or full speed. A mode code selects the first diode or the second diode. A third mode runs the two diodes back to back and reports the first count minus the second as signed data. A fourth mode does nothing. The `diode_sel` output drives the photodiode multiplexer. Enable low holds the converter in reset. Power-down freezes all counting.

Top module: `lux_integ_ctrl`

## Requirements
- R1: In internal timing (`cfg_ext`=0), a window lasts exactly 2^n counted oscillator cycles, where `cfg_width` 0, 1, 2, 3 gives n = 16, 12, 8, 4. A new window starts on the next cycle without any command.
- R2: With `cfg_range` 0 or 1, only every second `osc_tick` is counted (half speed). With `cfg_range` 2 or 3, every `osc_tick` is counted.
- R3: The sensor result is the number of counted oscillator cycles on which `mod_pulse` was 1. `diode_sel` is 0 for mode 0 and 1 for mode 1.
- R4: In external timing (`cfg_ext`=1), the first sync after enable only starts a window and gives no result. Each later sync ends the window, so a counted cycle on that same edge belongs to the ending window, and a new window starts at once.
- R5: Mode 2 runs a diode-1 window (`diode_sel`=0) and then a diode-2 window (`diode_sel`=1). Only the end of the diode-2 window gives a result: the two's-complement difference diode1 minus diode2, clamped to the signed RES_W-bit range. The timer result is the diode-2 window length.
- R6: Mode 3 performs no operation: no counting and no end-of-conversion.
- R7: The timer result is the length of the finished window in counted cycles, clamped to 0xFFFF. In external timing the timer counter saturates at 0xFFFF and sets `ovf_flag`. The flag stays set until enable goes low.
- R8: With `cfg_enable`=0, all counters, the sequence state, both results and `ovf_flag` clear on the next edge. With `cfg_pdown`=1, counting, window ends and syncs are frozen, and the window resumes where it stopped.
- R9: `eoc` is high for one cycle at the end of each result-producing window. Both results change only in that cycle, so the sensor/timer pair is always consistent.
- R10: In internal timing, `sync_stb` has no effect on window length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Clock enable from the oscillator model |
| mod_pulse | input | 1 | Modulator count-enable for the current cycle |
| sync_stb | input | 1 | One-cycle sync command from the bus interface |
| cfg_enable | input | 1 | 0 holds the converter in reset |
| cfg_pdown | input | 1 | 1 freezes all counting |
| cfg_ext | input | 1 | 0 internal timing, 1 sync-framed timing |
| cfg_mode | input | 2 | 0 diode 1, 1 diode 2, 2 difference, 3 idle |
| cfg_width | input | 2 | Internal window length code |
| cfg_range | input | 2 | Range code; 0/1 half speed, 2/3 full speed |
| sensor_out | output | RES_W | Latest sensor result |
| timer_out | output | RES_W | Window length matching the sensor result |
| eoc | output | 1 | End-of-conversion strobe |
| ovf_flag | output | 1 | Sticky timer saturation flag |
| diode_sel | output | 1 | Photodiode multiplexer select |

## Verification
The assertions assume that mode, width, range and timing selection change only while `cfg_enable` is low. Only enable and power-down are treated as run-time controls. The stability property on the results also assumes that a disable edge is the only other path that may change them. The bench reconfigures only inside a disabled gap of at least two cycles. It toggles power-down and sync freely, because the design must tolerate those at any time.

// File: rtl/lic_pkg.sv
package lic_pkg;
  typedef enum logic [1:0] {
    MD_DIODE1 = 2'd0,
    MD_DIODE2 = 2'd1,
    MD_DIFF   = 2'd2,
    MD_IDLE   = 2'd3
  } mode_e;
endpackage

// File: rtl/lic_rst_sync.sv
module lic_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/lic_tick_gen.sv
module lic_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hold,
  input  logic half,
  input  logic osc_tick,
  output logic ctick
);
  logic phase_q, phase_n;

  always_comb begin
    phase_n = phase_q;
    if (clr)                    phase_n = 1'b0;
    else if (!hold && osc_tick) phase_n = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_n;
  end

  // half speed: count only the second tick of each pair
  assign ctick = !clr && !hold && osc_tick && (!half || phase_q);
endmodule

// File: rtl/lic_window_seq.sv
module lic_window_seq #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic             ext,
  input  logic             dual,
  input  logic [1:0]       width,
  input  logic             ctick,
  input  logic             mod_pulse,
  input  logic             sync_stb,
  output logic             win_end,
  output logic             stage,
  output logic [RES_W:0]   end_acc,
  output logic [RES_W:0]   end_tmr,
  output logic             sat_hit
);
  localparam int CW   = RES_W + 1;
  localparam int STEP = RES_W / 4;
  localparam int SH_W = $clog2(RES_W + 1);
  localparam logic [CW-1:0] TMAX = {1'b0, {RES_W{1'b1}}};

  logic [CW-1:0]   tcnt_q, tcnt_n, acc_q, acc_n, t_inc, a_inc, win_len;
  logic            stage_q, stage_n, armed_q, armed_n;
  logic [SH_W-1:0] sh;
  logic            active, tick_ok, int_end, ext_end, ext_start;

  always_comb begin
    sh        = SH_W'(RES_W) - SH_W'(STEP) * SH_W'(width);
    win_len   = CW'(1) << sh;
    active    = !clr && !hold;
    tick_ok   = ctick && (!ext || (armed_q && tcnt_q != TMAX));
    sat_hit   = active && ctick && ext && armed_q && (tcnt_q == TMAX);
    t_inc     = tcnt_q + CW'(tick_ok);
    a_inc     = acc_q + CW'(tick_ok && mod_pulse);
    int_end   = !ext && tick_ok && (t_inc == win_len);
    ext_end   = ext && armed_q && sync_stb;
    ext_start = active && ext && !armed_q && sync_stb;
    win_end   = active && (int_end || ext_end);
  end

  always_comb begin
    tcnt_n  = tcnt_q;
    acc_n   = acc_q;
    stage_n = stage_q;
    armed_n = armed_q;
    if (clr) begin
      tcnt_n  = '0;
      acc_n   = '0;
      stage_n = 1'b0;
      armed_n = 1'b0;
    end else if (win_end) begin
      tcnt_n  = '0;
      acc_n   = '0;
      stage_n = dual ? ~stage_q : 1'b0;
    end else if (ext_start) begin
      tcnt_n  = '0;
      acc_n   = '0;
      stage_n = 1'b0;
      armed_n = 1'b1;
    end else if (active) begin
      tcnt_n  = t_inc;
      acc_n   = a_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q  <= '0;
      acc_q   <= '0;
      stage_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      tcnt_q  <= tcnt_n;
      acc_q   <= acc_n;
      stage_q <= stage_n;
      armed_q <= armed_n;
    end
  end

  assign stage   = stage_q;
  assign end_acc = a_inc;
  assign end_tmr = t_inc;
endmodule

// File: rtl/lic_result.sv
module lic_result #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             win_end,
  input  logic             dual,
  input  logic             stage,
  input  logic [RES_W:0]   end_acc,
  input  logic [RES_W:0]   end_tmr,
  input  logic             sat_hit,
  output logic [RES_W-1:0] sensor_out,
  output logic [RES_W-1:0] timer_out,
  output logic             eoc,
  output logic             ovf_flag
);
  localparam int CW = RES_W + 1;
  localparam int DW = RES_W + 2;
  localparam logic signed [DW-1:0] SMAX = $signed({3'b000, {(RES_W-1){1'b1}}});
  localparam logic signed [DW-1:0] SMIN = $signed({3'b111, {(RES_W-1){1'b0}}});

  logic [RES_W-1:0]       sens_q, sens_n, tmr_q, tmr_n;
  logic [CW-1:0]          d1_q, d1_n;
  logic                   eoc_q, eoc_n, ovf_q, ovf_n;
  logic signed [DW-1:0]   diff, diff_c;

  function automatic logic [RES_W-1:0] sat_u(input logic [CW-1:0] x);
    return x[RES_W] ? {RES_W{1'b1}} : x[RES_W-1:0];
  endfunction

  always_comb begin
    diff   = $signed({1'b0, d1_q}) - $signed({1'b0, end_acc});
    diff_c = (diff > SMAX) ? SMAX : ((diff < SMIN) ? SMIN : diff);
  end

  always_comb begin
    sens_n = sens_q;
    tmr_n  = tmr_q;
    d1_n   = d1_q;
    ovf_n  = ovf_q;
    eoc_n  = 1'b0;
    if (clr) begin
      sens_n = '0;
      tmr_n  = '0;
      d1_n   = '0;
      ovf_n  = 1'b0;
    end else begin
      if (sat_hit) ovf_n = 1'b1;
      if (win_end) begin
        if (dual && !stage) begin
          d1_n = end_acc;
        end else begin
          eoc_n  = 1'b1;
          tmr_n  = sat_u(end_tmr);
          sens_n = dual ? diff_c[RES_W-1:0] : sat_u(end_acc);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sens_q <= '0;
      tmr_q  <= '0;
      d1_q   <= '0;
      eoc_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      sens_q <= sens_n;
      tmr_q  <= tmr_n;
      d1_q   <= d1_n;
      eoc_q  <= eoc_n;
      ovf_q  <= ovf_n;
    end
  end

  assign sensor_out = sens_q;
  assign timer_out  = tmr_q;
  assign eoc        = eoc_q;
  assign ovf_flag   = ovf_q;
endmodule

// File: rtl/lux_integ_ctrl.sv
module lux_integ_ctrl #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             mod_pulse,
  input  logic             sync_stb,
  input  logic             cfg_enable,
  input  logic             cfg_pdown,
  input  logic             cfg_ext,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_width,
  input  logic [1:0]       cfg_range,
  output logic [RES_W-1:0] sensor_out,
  output logic [RES_W-1:0] timer_out,
  output logic             eoc,
  output logic             ovf_flag,
  output logic             diode_sel
);
  import lic_pkg::*;

  mode_e          md;
  logic           rst_n_i, clr, hold, half, dual, ctick;
  logic           win_end, stage, sat_hit;
  logic [RES_W:0] end_acc, end_tmr;

  assign md   = mode_e'(cfg_mode);
  assign clr  = !cfg_enable;
  assign hold = cfg_pdown || (md == MD_IDLE);
  assign half = (cfg_range == 2'd0) || (cfg_range == 2'd1);
  assign dual = (md == MD_DIFF);
  assign diode_sel = dual ? stage : (md == MD_DIODE2);

  lic_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  lic_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n_i), .clr(clr), .hold(hold),
    .half(half), .osc_tick(osc_tick), .ctick(ctick)
  );

  lic_window_seq #(.RES_W(RES_W)) u_seq (
    .clk(clk), .rst_n(rst_n_i), .clr(clr), .hold(hold),
    .ext(cfg_ext), .dual(dual), .width(cfg_width), .ctick(ctick),
    .mod_pulse(mod_pulse), .sync_stb(sync_stb), .win_end(win_end),
    .stage(stage), .end_acc(end_acc), .end_tmr(end_tmr), .sat_hit(sat_hit)
  );

  lic_result #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n_i), .clr(clr), .win_end(win_end),
    .dual(dual), .stage(stage), .end_acc(end_acc), .end_tmr(end_tmr),
    .sat_hit(sat_hit), .sensor_out(sensor_out), .timer_out(timer_out),
    .eoc(eoc), .ovf_flag(ovf_flag)
  );
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic             cfg_pdown,
  input logic [1:0]       cfg_mode,
  input logic [RES_W-1:0] sensor_out,
  input logic [RES_W-1:0] timer_out,
  input logic             eoc,
  input logic             ovf_flag
);
  // R8: disable clears everything on the next edge
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (sensor_out == '0 && timer_out == '0 && !eoc && !ovf_flag));

  // R8: frozen while powered down
  a_r8_pdown_no_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cfg_pdown) |=> !eoc);

  // R6: idle mode never reports
  a_r6_idle_no_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd3) |=> !eoc);

  // R7: overflow flag is sticky while enabled
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && cfg_enable) |=> ovf_flag);

  // R9: results move only together with the strobe
  a_r9_results_atomic: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc && $past(cfg_enable)) |-> ($stable(sensor_out) && $stable(timer_out)));
endmodule

bind lux_integ_ctrl lic_checker #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_pdown(cfg_pdown),
  .cfg_mode(cfg_mode), .sensor_out(sensor_out), .timer_out(timer_out),
  .eoc(eoc), .ovf_flag(ovf_flag)
);

// File: tb/tb_lux_integ_ctrl.sv
module tb_lux_integ_ctrl;
  logic        clk, rst_n, osc_tick, mod_pulse, sync_stb;
  logic        cfg_enable, cfg_pdown, cfg_ext;
  logic [1:0]  cfg_mode, cfg_width, cfg_range;
  logic [15:0] sensor_out, timer_out;
  logic        eoc, ovf_flag, diode_sel;
  int          n_chk = 0;
  int          n_bad = 0;

  lux_integ_ctrl #(.RES_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .mod_pulse(mod_pulse),
    .sync_stb(sync_stb), .cfg_enable(cfg_enable), .cfg_pdown(cfg_pdown),
    .cfg_ext(cfg_ext), .cfg_mode(cfg_mode), .cfg_width(cfg_width),
    .cfg_range(cfg_range), .sensor_out(sensor_out), .timer_out(timer_out),
    .eoc(eoc), .ovf_flag(ovf_flag), .diode_sel(diode_sel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  md;
    logic [1:0]  wd;
    logic [1:0]  rg;
    logic [15:0] sens;
    logic [15:0] tmr;
    logic [16:0] cyc;
  } vec_t;

  // modulator pulses on every third cycle from enable
  localparam vec_t VECS [8] = '{
    '{2'd0, 2'd3, 2'd2, 16'd6,     16'd16,    17'd16},
    '{2'd0, 2'd3, 2'd0, 16'd5,     16'd16,    17'd32},
    '{2'd1, 2'd3, 2'd3, 16'd6,     16'd16,    17'd16},
    '{2'd0, 2'd2, 2'd2, 16'd86,    16'd256,   17'd256},
    '{2'd0, 2'd2, 2'd1, 16'd85,    16'd256,   17'd512},
    '{2'd0, 2'd1, 2'd2, 16'd1366,  16'd4096,  17'd4096},
    '{2'd2, 2'd3, 2'd2, 16'd1,     16'd16,    17'd32},
    '{2'd0, 2'd0, 2'd2, 16'd21846, 16'd65535, 17'd65536}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic start_cfg(input logic [1:0] md, input logic [1:0] wd,
                           input logic [1:0] rg, input logic ext);
    @(negedge clk);
    cfg_enable = 1'b0; cfg_pdown = 1'b0; cfg_ext = ext;
    cfg_mode = md; cfg_width = wd; cfg_range = rg;
    mod_pulse = 1'b0; sync_stb = 1'b0; osc_tick = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_int(input int sync_at, input int pd_from, input int pd_len,
                         output int cyc, output bit early);
    int c;
    c = 0; early = 1'b0;
    while (c < 190000) begin
      if (c > 0) begin
        @(negedge clk);
        if (eoc) break;
        if (sensor_out != 16'd0 || timer_out != 16'd0) early = 1'b1;
      end
      cfg_enable = 1'b1;
      mod_pulse  = (c % 3 == 0);
      sync_stb   = (c == sync_at);
      cfg_pdown  = (pd_len > 0) && (c >= pd_from) && (c < pd_from + pd_len);
      c++;
    end
    cyc = c;
    sync_stb = 1'b0; cfg_pdown = 1'b0;
  endtask

  task automatic drv(input logic p, input logic s);
    mod_pulse = p; sync_stb = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all-requirements: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int  cyc, k, seen;
    bit  early;
    rst_n = 1'b0; osc_tick = 1'b0; mod_pulse = 1'b0; sync_stb = 1'b0;
    cfg_enable = 1'b0; cfg_pdown = 1'b0; cfg_ext = 1'b0;
    cfg_mode = 2'd0; cfg_width = 2'd3; cfg_range = 2'd2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset / disabled state
    chk("R8", "reset sensor", 32'(sensor_out), 32'd0);
    chk("R8", "reset timer", 32'(timer_out), 32'd0);
    chk("R9", "reset eoc", 32'(eoc), 32'd0);
    chk("R7", "reset ovf", 32'(ovf_flag), 32'd0);

    // R1 R2 R3 R5 R9 table walk
    for (int i = 0; i < 8; i++) begin
      start_cfg(VECS[i].md, VECS[i].wd, VECS[i].rg, 1'b0);
      run_int(-1, 0, 0, cyc, early);
      chk("R1", $sformatf("vec%0d window cycles", i), 32'(cyc), 32'(VECS[i].cyc));
      chk("R3", $sformatf("vec%0d sensor", i), 32'(sensor_out), 32'(VECS[i].sens));
      chk("R7", $sformatf("vec%0d timer", i), 32'(timer_out), 32'(VECS[i].tmr));
      chk("R9", $sformatf("vec%0d no early update", i), 32'(early), 32'd0);
      chk("R3", $sformatf("vec%0d diode_sel", i), 32'(diode_sel),
          32'(VECS[i].md == 2'd1));
      @(negedge clk);
      chk("R9", $sformatf("vec%0d eoc one cycle", i), 32'(eoc), 32'd0);
    end

    // R10 sync ignored in internal timing; R1 automatic restart
    start_cfg(2'd0, 2'd3, 2'd2, 1'b0);
    run_int(5, 0, 0, cyc, early);
    chk("R10", "sync ignored window", 32'(cyc), 32'd16);
    chk("R10", "sync ignored timer", 32'(timer_out), 32'd16);
    k = 0;
    do begin @(negedge clk); k++; end while (!eoc && k < 100);
    chk("R1", "restart period", 32'(k), 32'd16);

    // R8 power-down freezes and resumes
    start_cfg(2'd0, 2'd3, 2'd2, 1'b0);
    run_int(-1, 4, 10, cyc, early);
    chk("R8", "pdown stretched window", 32'(cyc), 32'd26);
    chk("R8", "pdown sensor", 32'(sensor_out), 32'd6);
    chk("R8", "pdown timer", 32'(timer_out), 32'd16);

    // R6 idle mode
    start_cfg(2'd3, 2'd3, 2'd2, 1'b0);
    cfg_enable = 1'b1;
    seen = 0;
    for (int j = 0; j < 40; j++) begin
      drv(1'b1, (j == 7));
      if (eoc) seen++;
    end
    chk("R6", "idle eoc count", 32'(seen), 32'd0);
    chk("R6", "idle sensor", 32'(sensor_out), 32'd0);

    // R4 external single-diode window
    start_cfg(2'd0, 2'd3, 2'd2, 1'b1);
    cfg_enable = 1'b1;
    drv(1'b1, 1'b0); drv(1'b0, 1'b0);
    drv(1'b0, 1'b1);
    repeat (7) drv(1'b1, 1'b0);
    repeat (3) drv(1'b0, 1'b0);
    chk("R4", "first sync gives no result", 32'(sensor_out), 32'd0);
    drv(1'b0, 1'b1);
    chk("R4", "ext eoc", 32'(eoc), 32'd1);
    chk("R4", "ext sensor", 32'(sensor_out), 32'd7);
    chk("R4", "ext timer", 32'(timer_out), 32'd11);
    drv(1'b0, 1'b0);
    chk("R9", "ext eoc one cycle", 32'(eoc), 32'd0);

    // R5 external difference sequence
    start_cfg(2'd2, 2'd3, 2'd2, 1'b1);
    cfg_enable = 1'b1;
    drv(1'b0, 1'b1);
    chk("R5", "diode1 phase select", 32'(diode_sel), 32'd0);
    repeat (4) drv(1'b1, 1'b0);
    drv(1'b0, 1'b1);
    chk("R5", "no eoc after diode1", 32'(eoc), 32'd0);
    chk("R5", "diode2 phase select", 32'(diode_sel), 32'd1);
    repeat (9) drv(1'b1, 1'b0);
    drv(1'b0, 1'b1);
    chk("R5", "diff eoc", 32'(eoc), 32'd1);
    chk("R5", "diff value -5", 32'(sensor_out), 32'h0000_FFFB);
    chk("R5", "diff timer", 32'(timer_out), 32'd10);
    chk("R5", "back to diode1", 32'(diode_sel), 32'd0);

    // R7 timer saturation and sticky flag
    start_cfg(2'd0, 2'd3, 2'd2, 1'b1);
    cfg_enable = 1'b1;
    drv(1'b0, 1'b1);
    repeat (65600) drv(1'b1, 1'b0);
    drv(1'b1, 1'b1);
    chk("R7", "sat timer", 32'(timer_out), 32'h0000_FFFF);
    chk("R7", "sat sensor", 32'(sensor_out), 32'h0000_FFFF);
    chk("R7", "ovf set", 32'(ovf_flag), 32'd1);
    repeat (3) drv(1'b1, 1'b0);
    drv(1'b0, 1'b1);
    chk("R7", "short window timer", 32'(timer_out), 32'd4);
    chk("R7", "ovf sticky", 32'(ovf_flag), 32'd1);
    cfg_enable = 1'b0;
    @(negedge clk);
    chk("R8", "disable clears ovf", 32'(ovf_flag), 32'd0);
    chk("R8", "disable clears sensor", 32'(sensor_out), 32'd0);
    chk("R8", "disable clears timer", 32'(timer_out), 32'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule